// File: doc/BRIEF.md
# STM-1 Transmit Frame Generator with Suppress Gate

This block builds the byte-wide transmit stream of a 155.52 Mbit/s synchronous optical frame, 270 columns by 9 rows (2430 bytes, one frame per 125 µs). An external byte-clock enable paces it. The first 10 columns of every row are overhead with fixed content. The other 260 columns carry 53-byte ATM cells, so the cell rate is 260/270 of the line rate (149.76 Mbit/s).

At each cell slot the block looks at a cell FIFO. The FIFO is first-word-fall-through and raises `cell_avail` when it holds at least one whole cell. If a cell is ready, its bytes are popped and sent. If not, an idle cell is sent.

A suppress input forces the output to a constant byte and abandons the frame at once. After suppress is released, output restarts at the first byte of a fresh frame. If a FIFO cell was cut off, the rest of its bytes are drained from the FIFO so that the FIFO stays cell-aligned.

Top module: `stm1_tx_framer`

## Requirements
- R1: While reset is low, and after it until the first enabled byte, `line_data` is 00h, `frame_start` is 0 and `fifo_pop` is 0.
- R2: Byte positions advance row-major (column 0..269, then next row, 9 rows) only on clocks with `byte_en` high. Outputs hold when `byte_en` is low. `frame_start` is high exactly while `line_data` carries row 0, column 0.
- R3: Columns 0..9 are overhead, with these values:
  - row 0, columns 0..2: F6h
  - row 0, columns 3..5: 28h
  - row 0, column 6: 01h
  - row 2, column 9: 13h
  - every other overhead byte: 00h
- R4: Columns 10..269 carry cells. At a cell's first byte, if `cell_avail` is high (and no drain is pending), the cell comes from the FIFO. Each of its 53 bytes is taken from `fifo_data` with `fifo_pop` high in that same enabled clock.
- R5: Without a ready cell, an idle cell is sent: header bytes 00h 00h 00h 01h 52h, then 48 bytes of 6Ah.
- R6: A cell that has started continues across overhead columns, row ends and frame ends. `cell_avail` is only looked at on a cell's first byte.
- R7: On every clock edge with `suppress` high, `line_data` becomes 00h and `frame_start` 0, whatever `byte_en` is.
- R8: After `suppress` falls, the first enabled byte is row 0, column 0 (F6h with `frame_start` high). The first payload byte of that frame starts a new cell.
- R9: When suppress cuts off a FIFO cell, its unsent bytes are popped one per enabled clock until none remain. While any remain, every new cell slot carries an idle cell.
- R10: `fifo_pop` is high only with `byte_en` high, and only for a FIFO cell byte being sent or a byte being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_en | input | 1 | Byte-clock enable, one line byte per high clock |
| suppress | input | 1 | Force constant output and abandon the frame |
| cell_avail | input | 1 | FIFO holds at least one whole cell |
| fifo_data | input | 8 | Head byte of the cell FIFO |
| fifo_pop | output | 1 | Take the head byte of the FIFO this clock |
| line_data | output | 8 | Registered transmit byte |
| frame_start | output | 1 | Marks the byte at row 0, column 0 |

## Verification
The following rules are checked by assertions on every clock:
- the constant output under suppress;
- holding while the enable is low;
- the frame marker byte;
- the idle header at slots with no ready cell;
- the pop at slots with a ready cell;
- popping during a drain.

The bench's scenarios are needed for the behaviours that span many clocks:
- the exact content of every overhead and idle position;
- cell bytes carried across rows and frames;
- restart at a fresh frame after release;
- a drain that outlasts the suppress pulse while cells wait in the FIFO.

These are shown by a behavioural model compared on every clock under continuous and gapped enables.

// File: rtl/stm1_tx_framer.sv
module stm1_tx_framer #(
  parameter int COLS = 270,
  parameter int ROWS = 9,
  parameter int OH_COLS = 10,
  parameter int CELL_LEN = 53,
  parameter logic [7:0] SUPP_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_en,
  input  logic       suppress,
  input  logic       cell_avail,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic [7:0] line_data,
  output logic       frame_start
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int KW = $clog2(CELL_LEN + 1);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [KW-1:0] cidx, owe;
  logic          csrc;
  logic [7:0]    oh_byte, idle_byte, nxt_byte;

  wire pay       = col >= CW'(OH_COLS);
  wire cstart    = pay && (cidx == '0);
  wire take      = cstart ? (cell_avail && owe == '0) : csrc;
  wire from_fifo = pay && take;
  wire last_col  = col == CW'(COLS - 1);
  wire last_row  = row == RW'(ROWS - 1);

  assign fifo_pop = byte_en && (owe != '0 || (!suppress && from_fifo));

  always_comb begin
    oh_byte = 8'h00;
    if (row == '0 && col < CW'(3))       oh_byte = 8'hF6;
    else if (row == '0 && col < CW'(6))  oh_byte = 8'h28;
    else if (row == '0 && col == CW'(6)) oh_byte = 8'h01;
    else if (row == RW'(2) && col == CW'(OH_COLS - 1)) oh_byte = 8'h13;
  end

  always_comb begin
    if (cidx == KW'(3))      idle_byte = 8'h01;
    else if (cidx == KW'(4)) idle_byte = 8'h52;
    else if (cidx < KW'(4))  idle_byte = 8'h00;
    else                     idle_byte = 8'h6A;
  end

  assign nxt_byte = !pay ? oh_byte : (from_fifo ? fifo_data : idle_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      cidx <= '0;
      owe <= '0;
      csrc <= 1'b0;
      line_data <= 8'h00;
      frame_start <= 1'b0;
    end else begin
      if (suppress && csrc && cidx != '0) owe <= KW'(CELL_LEN) - cidx;
      else if (byte_en && owe != '0)      owe <= owe - 1'b1;

      if (suppress) begin
        col <= '0;
        row <= '0;
        cidx <= '0;
        line_data <= SUPP_BYTE;
        frame_start <= 1'b0;
      end else if (byte_en) begin
        line_data <= nxt_byte;
        frame_start <= (row == '0) && (col == '0);
        col <= last_col ? '0 : col + 1'b1;
        if (last_col) row <= last_row ? '0 : row + 1'b1;
        if (pay) begin
          if (cstart) csrc <= take;
          cidx <= (cidx == KW'(CELL_LEN - 1)) ? '0 : cidx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stm1_tx_framer_chk.sv
module stm1_tx_framer_chk #(
  parameter int CW = 9,
  parameter int KW = 6,
  parameter int OH_COLS = 10,
  parameter logic [7:0] SUPP_BYTE = 8'h00
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_en,
  input logic          suppress,
  input logic          cell_avail,
  input logic          fifo_pop,
  input logic [7:0]    line_data,
  input logic          frame_start,
  input logic [CW-1:0] col,
  input logic [KW-1:0] cidx,
  input logic [KW-1:0] owe
);
  wire slot = byte_en && !suppress && col >= CW'(OH_COLS) && cidx == '0;

  a_r7_suppress_out: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> (line_data == SUPP_BYTE) && !frame_start);
  a_r10_pop_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> byte_en);
  a_r2_hold_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_en && !suppress) |=> $stable(line_data) && $stable(frame_start));
  a_r3_marker_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_data == 8'hF6);
  a_r5_idle_header: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !cell_avail) |=> line_data == 8'h00);
  a_r4_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && cell_avail && owe == '0) |-> fifo_pop);
  a_r9_drain_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && owe != '0) |-> fifo_pop);
endmodule

bind stm1_tx_framer stm1_tx_framer_chk #(.CW(CW), .KW(KW), .OH_COLS(OH_COLS), .SUPP_BYTE(SUPP_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .suppress(suppress),
  .cell_avail(cell_avail), .fifo_pop(fifo_pop), .line_data(line_data),
  .frame_start(frame_start), .col(col), .cidx(cidx), .owe(owe)
);

// File: tb/stm1_tx_framer_test.sv
`timescale 1ns/1ps
module stm1_tx_framer_test;
  logic clk = 0, rst_n = 0, byte_en = 0, suppress = 0, cell_avail = 0;
  logic [7:0] fifo_data = 0;
  logic fifo_pop, frame_start;
  logic [7:0] line_data;
  always #10 clk = ~clk;

  stm1_tx_framer uut (.clk(clk), .rst_n(rst_n), .byte_en(byte_en), .suppress(suppress),
    .cell_avail(cell_avail), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .line_data(line_data), .frame_start(frame_start));

  int checks = 0, fails = 0, cyc = 0, ncell = 0;
  bit done = 0, gapped = 0;
  logic [7:0] q[$];
  int m_row = 0, m_col = 0, m_cidx = 0, m_owe = 0;
  bit m_csrc = 0, rel_pend = 0;
  logic [7:0] exp_line = 0;
  bit exp_fs = 0;
  string exp_tag = "R1";

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit mpop();
    bit start_take;
    start_take = (m_cidx == 0) ? (q.size() >= 53 && m_owe == 0) : m_csrc;
    return byte_en && (m_owe > 0 || (!suppress && m_col >= 10 && start_take));
  endfunction

  function automatic logic [7:0] oh(int r, int c);
    if (r == 0 && c < 3) return 8'hF6;
    if (r == 0 && c < 6) return 8'h28;
    if (r == 0 && c == 6) return 8'h01;
    if (r == 2 && c == 9) return 8'h13;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_row = 0; m_col = 0; m_cidx = 0; m_owe = 0; m_csrc = 0;
      exp_line = 0; exp_fs = 0; exp_tag = "R1";
    end else begin
      bit p;
      int nowe;
      logic [7:0] head;
      p = mpop();
      head = q.size() > 0 ? q[0] : 8'h00;
      nowe = m_owe;
      if (suppress && m_csrc && m_cidx > 0) nowe = 53 - m_cidx;
      else if (byte_en && m_owe > 0) nowe = m_owe - 1;
      if (suppress) begin
        m_row = 0; m_col = 0; m_cidx = 0;
        exp_line = 8'h00; exp_fs = 0; exp_tag = "R7"; rel_pend = 1;
      end else if (byte_en) begin
        exp_fs = (m_row == 0 && m_col == 0);
        if (m_col < 10) begin
          exp_line = oh(m_row, m_col); exp_tag = "R3";
        end else begin
          if (m_cidx == 0) m_csrc = (q.size() >= 53 && m_owe == 0);
          if (m_csrc) begin
            exp_line = head; exp_tag = (m_cidx > 0 && m_col == 10) ? "R6" : "R4";
          end else begin
            exp_line = (m_cidx == 3) ? 8'h01 : (m_cidx == 4) ? 8'h52 : (m_cidx < 4) ? 8'h00 : 8'h6A;
            exp_tag = (m_owe > 0) ? "R9" : "R5";
          end
          m_cidx = (m_cidx == 52) ? 0 : m_cidx + 1;
        end
        if (rel_pend) begin exp_tag = "R8"; rel_pend = 0; end
        m_col++;
        if (m_col == 270) begin m_col = 0; m_row = (m_row == 8) ? 0 : m_row + 1; end
      end
      m_owe = nowe;
      if (p) void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(line_data == exp_line, exp_tag, line_data, exp_line);
      chk(frame_start == exp_fs, "R2", frame_start, exp_fs);
      chk(fifo_pop == mpop(), m_owe > 0 ? "R9" : "R10", fifo_pop, mpop());
    end
  end

  task automatic sync_fifo();
    cell_avail = q.size() >= 53;
    fifo_data = q.size() > 0 ? q[0] : 8'h00;
  endtask

  task automatic push_cells(int n);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 53; i++) q.push_back(8'((ncell * 7 + i * 3 + 1) & 8'hFF));
      ncell++;
    end
    sync_fifo();
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cyc++;
      byte_en = gapped ? (cyc % 3 != 0) : 1'b1;
      #1 sync_fifo();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(line_data == 8'h00 && frame_start == 0 && fifo_pop == 0, "R1", line_data, 0);
    #2 rst_n = 1;
    step(2500);
    push_cells(3);
    step(3000);
    gapped = 1;
    push_cells(5);
    step(8000);
    gapped = 0;
    push_cells(8);
    for (int i = 0; i < 4000 && !(m_csrc && m_cidx >= 10 && m_cidx <= 30 && m_col >= 10); i++) step(1);
    suppress = 1;
    step(5);
    suppress = 0;
    step(3000);
    push_cells(4);
    for (int i = 0; i < 4000 && !(m_csrc && m_cidx >= 5 && m_cidx <= 40); i++) step(1);
    suppress = 1;
    step(6);
    gapped = 1;
    step(12);
    suppress = 0;
    step(6000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule